// File: doc/BRIEF.md
# Privilege-Masked Authority Register File

This block holds the four 64-bit authority registers of a processor core: a data authority mask, an instruction authority mask, a user override mask and a hypervisor override mask. Register-move requests arrive on one request port. Each request carries a register number, a write flag, a 64-bit data word and the current privilege flags (problem state and hypervisor). The block serves at most one request per cycle.

Each request follows one of three access paths: user, supervisor or hypervisor. A write in the user or supervisor path is not a plain store. Only the bits enabled by an override mask take the new data, and every other bit keeps its old value. A write in the hypervisor path replaces the whole register. Three kinds of request are refused: one the privilege level does not permit, one to a number the block does not implement, and one to the instruction mask when that register is configured out. A refused request leaves every register unchanged and raises a one-cycle fault flag. Read data is registered and appears on the cycle after the request.

A configuration input chooses the reset value of the hypervisor override mask. When it is set, that mask comes out of reset as all ones, so a supervisor can freely change the data mask.

Top module: `authmask_regfile`

## Requirements
- R1: The path is chosen in priority order. Problem state set selects the user path, whatever the hypervisor flag. Otherwise the hypervisor flag set selects the hypervisor path. Otherwise the supervisor path is used.
- R2: The register numbers are 0x01D for the data mask, 0x03D for the instruction mask, 0x09D for the user override and 0x15D for the hypervisor override. Any other number is unimplemented and faults.
- R3: In the user path the data mask can be read. A write to it gives (new AND user override) OR (old AND NOT user override).
- R4: In the supervisor path, writes to the data mask, the instruction mask and the user override use the same merge, with the hypervisor override as the mask.
- R5: In the hypervisor path, writes to any of the four registers replace all 64 bits.
- R6: In the user path, any access to the user override or the instruction mask is refused.
- R7: The hypervisor override can be read and written only in the hypervisor path. Any access to it from the user or supervisor path is refused.
- R8: Reset clears all four registers. The one exception is the hypervisor override, which resets to all ones while `ovr_preset` is high.
- R9: When `HAS_IMASK` is 0, every access to 0x03D is refused as unimplemented, in every path.
- R10: A refused request sets `priv_fault` for exactly the cycle after the request, and no register changes.
- R11: A read request sets `rd_valid` on the next cycle, with the 64-bit register value on `rd_data`. A refused read returns zero.
- R12: A write takes effect at the clock edge that ends its request cycle. A read issued on the very next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovr_preset | input | 1 | Reset value of the hypervisor override is all ones when high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_num | input | 10 | Register number |
| req_wdata | input | 64 | Write data |
| priv_problem | input | 1 | Problem-state (user) flag |
| priv_hyp | input | 1 | Hypervisor flag |
| rd_valid | output | 1 | Read result valid (one cycle after a read request) |
| rd_data | output | 64 | Read result, zero for a refused read |
| priv_fault | output | 1 | Refused request, one cycle after it |

## Verification
The assertions assume that `ovr_preset` is steady while reset is released and that a request's fields are meaningful only while `req_valid` is high. The stimulus changes the preset only while reset is held. It drives every request on a falling edge, so each field is stable across the edge that samples it. The random requests use every privilege combination, including problem state together with the hypervisor flag, and include unimplemented numbers. This means the merge assertions see every path, not only the legal ones.

// File: rtl/authmask_regfile.sv
module authmask_regfile #(
  parameter int XLEN      = 64,
  parameter int NUM_W     = 10,
  parameter bit HAS_IMASK = 1'b1,
  parameter logic [NUM_W-1:0] DMASK_NUM = 10'h01D,
  parameter logic [NUM_W-1:0] IMASK_NUM = 10'h03D,
  parameter logic [NUM_W-1:0] UOVR_NUM  = 10'h09D,
  parameter logic [NUM_W-1:0] HOVR_NUM  = 10'h15D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_preset,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NUM_W-1:0] req_num,
  input  logic [XLEN-1:0]  req_wdata,
  input  logic             priv_problem,
  input  logic             priv_hyp,
  output logic             rd_valid,
  output logic [XLEN-1:0]  rd_data,
  output logic             priv_fault
);

  logic [XLEN-1:0] dmask_q, imask_q, uovr_q, hovr_q;
  logic [XLEN-1:0] sel_val, ins_mask, merged;
  logic path_user, path_hyp, path_sup;
  logic hit_d, hit_i, hit_u, hit_h, allowed, do_wr;

  assign path_user = priv_problem;
  assign path_hyp  = !priv_problem && priv_hyp;
  assign path_sup  = !priv_problem && !priv_hyp;

  assign hit_d = (req_num == DMASK_NUM);
  assign hit_i = HAS_IMASK && (req_num == IMASK_NUM);
  assign hit_u = (req_num == UOVR_NUM);
  assign hit_h = (req_num == HOVR_NUM);

  assign allowed = hit_d || ((hit_i || hit_u) && !path_user) || (hit_h && path_hyp);
  assign do_wr   = req_valid && req_write && allowed;

  always_comb begin
    sel_val = '0;
    if (hit_d) sel_val = dmask_q;
    if (hit_i) sel_val = imask_q;
    if (hit_u) sel_val = uovr_q;
    if (hit_h) sel_val = hovr_q;
  end

  assign ins_mask = path_hyp ? {XLEN{1'b1}} : (path_user ? uovr_q : hovr_q);
  assign merged   = (req_wdata & ins_mask) | (sel_val & ~ins_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmask_q <= '0;
      imask_q <= '0;
      uovr_q  <= '0;
      hovr_q  <= ovr_preset ? {XLEN{1'b1}} : '0;
    end else if (do_wr) begin
      if (hit_d) dmask_q <= merged;
      if (hit_i) imask_q <= merged;
      if (hit_u) uovr_q  <= merged;
      if (hit_h) hovr_q  <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      priv_fault <= 1'b0;
    end else begin
      rd_valid   <= req_valid && !req_write;
      rd_data    <= (req_valid && !req_write && allowed) ? sel_val : '0;
      priv_fault <= req_valid && !allowed;
    end
  end

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !allowed) |-> ($stable(dmask_q) && $stable(imask_q) && $stable(uovr_q) && $stable(hovr_q))); // R10
  AST_FAULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> $past(req_valid)); // R10
  AST_USER_DMASK_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write && priv_problem && hit_d) |-> (((dmask_q ^ $past(dmask_q)) & ~$past(uovr_q)) == '0)); // R3
  AST_SUP_DMASK_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write && path_sup && hit_d) |-> (((dmask_q ^ $past(dmask_q)) & ~$past(hovr_q)) == '0)); // R4
  AST_HOVR_HYP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hovr_q) |-> $past(req_valid && req_write && priv_hyp && !priv_problem)); // R7
  AST_USER_UOVR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && priv_problem && !hit_d) |-> ($stable(uovr_q) && $stable(imask_q))); // R6
  AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && priv_fault) |-> (rd_data == '0)); // R11
  AST_RD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write)); // R11

endmodule

// File: tb/tb_authmask_regfile.sv
module tb_authmask_regfile;
  localparam logic [9:0] N_D = 10'h01D, N_I = 10'h03D, N_U = 10'h09D, N_H = 10'h15D;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, ovr_preset = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, priv_problem = 1'b0, priv_hyp = 1'b0;
  logic [9:0] req_num = '0;
  logic [63:0] req_wdata = '0;
  logic rd_valid, priv_fault, rd_valid_n, priv_fault_n;
  logic [63:0] rd_data, rd_data_n;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [63:0] m_d, m_i, m_u, m_h;

  always #10 clk = ~clk;

  authmask_regfile dut (.clk, .rst_n, .ovr_preset, .req_valid, .req_write, .req_num,
    .req_wdata, .priv_problem, .priv_hyp, .rd_valid, .rd_data, .priv_fault);
  authmask_regfile #(.HAS_IMASK(1'b0)) dut_noi (.clk, .rst_n, .ovr_preset, .req_valid,
    .req_write, .req_num, .req_wdata, .priv_problem, .priv_hyp,
    .rd_valid(rd_valid_n), .rd_data(rd_data_n), .priv_fault(priv_fault_n));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit permit(input logic [9:0] n, input bit pr, input bit hv);
    if (n == N_D) return 1'b1;
    if (n == N_I || n == N_U) return !pr;
    if (n == N_H) return !pr && hv;
    return 1'b0;
  endfunction

  function automatic logic [63:0] mval(input logic [9:0] n);
    case (n)
      N_D: return m_d;
      N_I: return m_i;
      N_U: return m_u;
      N_H: return m_h;
      default: return 64'h0;
    endcase
  endfunction

  task automatic do_reset(input bit pre);
    @(negedge clk);
    req_valid = 1'b0; rst_n = 1'b0; ovr_preset = pre;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_d = '0; m_i = '0; m_u = '0; m_h = pre ? ONES : '0;
  endtask

  task automatic op(input bit wr, input logic [9:0] n, input logic [63:0] d,
                    input bit pr, input bit hv, input string tag);
    logic [63:0] msk, exp_rd;
    bit ok;
    ok = permit(n, pr, hv);
    exp_rd = (!wr && ok) ? mval(n) : 64'h0;
    req_valid = 1'b1; req_write = wr; req_num = n; req_wdata = d;
    priv_problem = pr; priv_hyp = hv;
    @(negedge clk);
    chk(priv_fault == !ok, {tag, " fault"}, {63'h0, priv_fault}, {63'h0, !ok});
    chk(rd_valid == !wr, {tag, " rd_valid"}, {63'h0, rd_valid}, {63'h0, !wr});
    if (!wr) chk(rd_data == exp_rd, {tag, " rd_data"}, rd_data, exp_rd);
    if (wr && ok) begin
      msk = pr ? m_u : (hv ? ONES : m_h);
      case (n)
        N_D: m_d = (d & msk) | (m_d & ~msk);
        N_I: m_i = (d & msk) | (m_i & ~msk);
        N_U: m_u = (d & msk) | (m_u & ~msk);
        default: m_h = (d & msk) | (m_h & ~msk);
      endcase
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(1'b0);
    chk(!rd_valid && !priv_fault, "R8 outputs idle after reset", {62'h0, rd_valid, priv_fault}, 64'h0);
    op(0, N_D, 0, 0, 1, "R8 data mask reset");
    op(0, N_I, 0, 0, 1, "R8 instr mask reset");
    op(0, N_U, 0, 0, 1, "R8 user override reset");
    op(0, N_H, 0, 0, 1, "R8 hyp override reset");
    op(1, N_H, 64'h00FF_00FF_0000_FFFF, 0, 1, "R5 hyp write override");
    op(0, N_H, 0, 0, 1, "R12 read right after write");
    op(1, N_U, 64'hF0F0_F0F0_F0F0_F0F0, 0, 0, "R4 sup write user override");
    op(0, N_U, 0, 0, 0, "R4 user override merged");
    op(1, N_D, ONES, 1, 0, "R3 user write data mask");
    op(0, N_D, 0, 1, 0, "R3 data mask merged under user override");
    op(1, N_D, 64'h0, 1, 1, "R1 problem+hyp uses user path");
    op(0, N_D, 0, 0, 0, "R1 data mask after problem+hyp write");
    op(1, N_I, ONES, 0, 0, "R4 sup write instr mask");
    op(0, N_I, 0, 0, 1, "R4 instr mask merged");
    op(1, N_D, 64'h1234_5678_9ABC_DEF0, 0, 1, "R5 hyp full replace");
    op(0, N_D, 0, 1, 0, "R5 data mask replaced");
    op(1, N_U, ONES, 1, 0, "R6 user write user override refused");
    op(0, N_I, 0, 1, 0, "R6 user read instr mask refused");
    op(0, N_U, 0, 0, 1, "R6 user override unchanged");
    op(1, N_H, ONES, 0, 0, "R7 sup write hyp override refused");
    op(0, N_H, 0, 1, 1, "R7 problem+hyp read hyp override refused");
    op(0, N_H, 0, 0, 1, "R7 hyp override unchanged");
    op(1, 10'h2A0, ONES, 0, 1, "R2 unimplemented number write");
    op(0, 10'h01C, 0, 0, 1, "R2 unimplemented number read");
    req_valid = 1'b1; req_write = 1'b0; req_num = N_I; priv_problem = 1'b0; priv_hyp = 1'b1;
    @(negedge clk);
    chk(priv_fault_n == 1'b1, "R9 absent instr mask faults", {63'h0, priv_fault_n}, 64'h1);
    chk(rd_data_n == 64'h0, "R9 absent instr mask reads zero", rd_data_n, 64'h0);
    chk(rd_data == m_i && !priv_fault, "R9 present instr mask readable", rd_data, m_i);
    idle();
    chk(!priv_fault && !rd_valid, "R10 fault lasts one cycle", {62'h0, priv_fault, rd_valid}, 64'h0);
    for (int k = 0; k < 3000; k++) begin
      logic [9:0] n;
      logic [63:0] d;
      int sel;
      sel = $urandom % 6;
      n = (sel == 0) ? N_D : (sel == 1) ? N_I : (sel == 2) ? N_U : (sel == 3) ? N_H :
          (sel == 4) ? N_D : 10'($urandom);
      d = {$urandom, $urandom};
      op(1'($urandom), n, d, 1'($urandom), 1'($urandom), "R11 random access");
      if ($urandom % 16 == 0) idle();
    end
    do_reset(1'b1);
    op(0, N_H, 0, 0, 1, "R8 preset hyp override ones");
    op(1, N_D, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, "R8 sup full control with preset");
    op(0, N_D, 0, 1, 0, "R8 data mask fully written");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule